// File: doc/BRIEF.md
# Scan Test Pattern Sequencer

This block drives one or more multiplexed scan chains from the test side. It holds a fixed set of test vectors as parameters. Each vector gives, for every chain, a stimulus word, an expected response word and a care mask. After a start request the block loads the first stimulus serially with the scan enable high. It then gives a single capture clock with the scan enable low. Next it unloads the captured response while the following stimulus goes in on the same clocks. Each bit that leaves a chain is compared with the expected bit as it arrives.

The chain is clocked by the system clock qualified with the clock-enable output. The block reports a device failure together with the index of the first vector that showed a mismatch. The run always completes through every vector before the done pulse, so the time a run takes depends only on the parameters.

Top module: `scan_seq`

## Requirements
- R1: While reset is held, and after it until the first start, busy, done, clk_en, scan_en, dev_fail and fail_vec are all 0.
- R2: A start pulse seen while idle makes busy rise at the next clock edge. The first CHAIN_LEN busy cycles are load shifts with clk_en=1 and scan_en=1. The stimulus word is sent most significant bit first, so pattern bit j ends up in chain flop j, where flop 0 is the one nearest scan_in.
- R3: Each vector gets exactly one capture cycle, with clk_en=1 and scan_en=0. A shift cycle with clk_en=1 and scan_en=1 always follows it, so a run has NUM_VEC capture cycles.
- R4: Every capture is preceded by exactly CHAIN_LEN shift cycles. After the first capture, the unload of vector v and the load of vector v+1 happen on those same cycles. The last vector is followed by CHAIN_LEN unload-only cycles, so busy lasts (NUM_VEC+1)*CHAIN_LEN+NUM_VEC cycles.
- R5: In unload cycle i (counting from 0), the scan_out bit is compared with expected bit CHAIN_LEN-1-i. The comparison counts only where the care bit is 1; a care bit of 0 means the position is not checked.
- R6: The first mismatch of a run sets dev_fail and stores that vector's index in fail_vec. Later mismatches change neither output, and the run continues to the end.
- R7: done is high for exactly one cycle, in the cycle right after busy falls. dev_fail and fail_vec then hold until the next accepted start, which clears them.
- R8: A start seen while a run is in progress, or in the done cycle, has no effect. The run keeps its length and its result.
- R9: Pattern bit (v*NUM_CHAINS+c)*CHAIN_LEN+j of STIM, EXPECT and CARE belongs to vector v, chain c, flop j. Each chain has its own scan_in and scan_out, and a mismatch on any chain counts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; also clocks the chains when clk_en is high |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| start | input | 1 | Request to run all vectors |
| scan_out | input | NUM_CHAINS | Last-flop output of each chain |
| busy | output | 1 | Run in progress |
| done | output | 1 | One-cycle pulse at the end of a run |
| scan_en | output | 1 | Chain mode: 1 shift, 0 capture |
| clk_en | output | 1 | Chain clock qualifier |
| scan_in | output | NUM_CHAINS | Serial stimulus for each chain |
| dev_fail | output | 1 | A compared bit differed during the run |
| fail_vec | output | VID_W | Index of the first failing vector |

## Verification
A wrong bit counter or vector index shows up first as a stimulus that lands in the wrong flops. The device then captures the wrong response, and dev_fail rises within the same run even though no fault is injected. It is also visible one capture later, as a capture cycle that does not follow exactly CHAIN_LEN shifts. A faulty compare order or a faulty care mask shows only when a stuck node is injected. The run then reports the wrong pass/fail or the wrong first-failing index at the done pulse, so the bench injects faults whose first detecting vector is known and checks that index.

// File: rtl/scan_seq_pkg.sv
package scan_seq_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_LOAD,
    ST_CAPT,
    ST_SHIFT,
    ST_FINAL,
    ST_DONE
  } seq_state_e;

  function automatic int idx_width(input int n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction
endpackage

// File: rtl/scan_seq_ctrl.sv
module scan_seq_ctrl
  import scan_seq_pkg::*;
#(
  parameter int CHAIN_LEN = 8,
  parameter int NUM_VEC   = 4,
  parameter int CNT_W     = idx_width(CHAIN_LEN),
  parameter int VID_W     = idx_width(NUM_VEC)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  output logic             busy,
  output logic             done,
  output logic             scan_en,
  output logic             clk_en,
  output logic             load_en,
  output logic             cmp_en,
  output logic             accept,
  output logic [VID_W-1:0] load_vec,
  output logic [VID_W-1:0] cur_vec,
  output logic [CNT_W-1:0] bit_sel
);
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(CHAIN_LEN - 1);
  localparam logic [VID_W-1:0] VID_LAST = VID_W'(NUM_VEC - 1);

  seq_state_e       st_q, st_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [VID_W-1:0] vid_q, vid_d;
  logic             cnt_last, vid_last;

  assign cnt_last = (cnt_q == CNT_LAST);
  assign vid_last = (vid_q == VID_LAST);

  always_comb begin
    st_d  = st_q;
    cnt_d = cnt_q;
    vid_d = vid_q;
    case (st_q)
      ST_IDLE: begin
        if (start) begin
          st_d  = ST_LOAD;
          cnt_d = '0;
          vid_d = '0;
        end
      end
      ST_LOAD: begin
        if (cnt_last) begin
          st_d  = ST_CAPT;
          cnt_d = '0;
        end else begin
          cnt_d = cnt_q + CNT_W'(1);
        end
      end
      ST_CAPT: begin
        st_d  = vid_last ? ST_FINAL : ST_SHIFT;
        cnt_d = '0;
      end
      ST_SHIFT: begin
        if (cnt_last) begin
          st_d  = ST_CAPT;
          cnt_d = '0;
          vid_d = vid_q + VID_W'(1);
        end else begin
          cnt_d = cnt_q + CNT_W'(1);
        end
      end
      ST_FINAL: begin
        if (cnt_last) st_d = ST_DONE;
        else          cnt_d = cnt_q + CNT_W'(1);
      end
      ST_DONE:  st_d = ST_IDLE;
      default:  st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= ST_IDLE;
      cnt_q <= '0;
      vid_q <= '0;
    end else begin
      st_q  <= st_d;
      cnt_q <= cnt_d;
      vid_q <= vid_d;
    end
  end

  always_comb begin
    busy     = (st_q == ST_LOAD) || (st_q == ST_CAPT) ||
               (st_q == ST_SHIFT) || (st_q == ST_FINAL);
    done     = (st_q == ST_DONE);
    clk_en   = busy;
    scan_en  = (st_q == ST_LOAD) || (st_q == ST_SHIFT) || (st_q == ST_FINAL);
    load_en  = (st_q == ST_LOAD) || (st_q == ST_SHIFT);
    cmp_en   = (st_q == ST_SHIFT) || (st_q == ST_FINAL);
    accept   = (st_q == ST_IDLE) && start;
    load_vec = (st_q == ST_SHIFT) ? (vid_q + VID_W'(1)) : vid_q;
    cur_vec  = vid_q;
    bit_sel  = CNT_LAST - cnt_q;
  end
endmodule

// File: rtl/scan_seq_lane.sv
module scan_seq_lane #(
  parameter int CHAIN_LEN  = 8,
  parameter int NUM_VEC    = 4,
  parameter int NUM_CHAINS = 2,
  parameter int CHAIN_IDX  = 0,
  parameter int CNT_W      = 3,
  parameter int VID_W      = 2,
  parameter int PAT_W      = NUM_VEC * NUM_CHAINS * CHAIN_LEN,
  parameter logic [PAT_W-1:0] STIM   = '0,
  parameter logic [PAT_W-1:0] EXPECT = '0,
  parameter logic [PAT_W-1:0] CARE   = '1
) (
  input  logic             load_en,
  input  logic             cmp_en,
  input  logic [VID_W-1:0] load_vec,
  input  logic [VID_W-1:0] cur_vec,
  input  logic [CNT_W-1:0] bit_sel,
  input  logic             chain_out,
  output logic             chain_in,
  output logic             miss
);
  localparam int IDX_W = (PAT_W > 1) ? $clog2(PAT_W) : 1;

  logic [IDX_W-1:0] ld_idx, cmp_idx;

  always_comb begin
    ld_idx  = IDX_W'((int'(load_vec) * NUM_CHAINS + CHAIN_IDX) * CHAIN_LEN + int'(bit_sel));
    cmp_idx = IDX_W'((int'(cur_vec) * NUM_CHAINS + CHAIN_IDX) * CHAIN_LEN + int'(bit_sel));
    chain_in = load_en ? STIM[ld_idx] : 1'b0;
    miss     = cmp_en && CARE[cmp_idx] && (chain_out != EXPECT[cmp_idx]);
  end
endmodule

// File: rtl/scan_seq_result.sv
module scan_seq_result #(
  parameter int VID_W = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clear,
  input  logic             miss_any,
  input  logic [VID_W-1:0] cur_vec,
  output logic             dev_fail,
  output logic [VID_W-1:0] fail_vec
);
  logic             fail_d;
  logic [VID_W-1:0] vec_d;
  logic             upd;

  always_comb begin
    upd    = clear || (miss_any && !dev_fail);
    fail_d = clear ? 1'b0 : 1'b1;
    vec_d  = clear ? '0 : cur_vec;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dev_fail <= 1'b0;
      fail_vec <= '0;
    end else if (upd) begin
      dev_fail <= fail_d;
      fail_vec <= vec_d;
    end
  end
endmodule

// File: rtl/scan_seq.sv
module scan_seq
  import scan_seq_pkg::*;
#(
  parameter int CHAIN_LEN  = 8,
  parameter int NUM_VEC    = 4,
  parameter int NUM_CHAINS = 2,
  parameter logic [NUM_VEC*NUM_CHAINS*CHAIN_LEN-1:0] STIM   = '0,
  parameter logic [NUM_VEC*NUM_CHAINS*CHAIN_LEN-1:0] EXPECT = '0,
  parameter logic [NUM_VEC*NUM_CHAINS*CHAIN_LEN-1:0] CARE   = '1
) (
  input  logic                               clk,
  input  logic                               rst_n,
  input  logic                               start,
  input  logic [NUM_CHAINS-1:0]              scan_out,
  output logic                               busy,
  output logic                               done,
  output logic                               scan_en,
  output logic                               clk_en,
  output logic [NUM_CHAINS-1:0]              scan_in,
  output logic                               dev_fail,
  output logic [idx_width(NUM_VEC)-1:0]      fail_vec
);
  localparam int CNT_W = idx_width(CHAIN_LEN);
  localparam int VID_W = idx_width(NUM_VEC);
  localparam int PAT_W = NUM_VEC * NUM_CHAINS * CHAIN_LEN;

  logic [1:0]            rst_sync_q;
  logic                  rst_int_n;
  logic                  load_en, cmp_en, accept;
  logic [VID_W-1:0]      load_vec, cur_vec;
  logic [CNT_W-1:0]      bit_sel;
  logic [NUM_CHAINS-1:0] miss;

  // asynchronous assertion, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  scan_seq_ctrl #(
    .CHAIN_LEN(CHAIN_LEN), .NUM_VEC(NUM_VEC), .CNT_W(CNT_W), .VID_W(VID_W)
  ) u_ctrl (
    .clk(clk), .rst_n(rst_int_n), .start(start),
    .busy(busy), .done(done), .scan_en(scan_en), .clk_en(clk_en),
    .load_en(load_en), .cmp_en(cmp_en), .accept(accept),
    .load_vec(load_vec), .cur_vec(cur_vec), .bit_sel(bit_sel)
  );

  for (genvar c = 0; c < NUM_CHAINS; c++) begin : g_lane
    scan_seq_lane #(
      .CHAIN_LEN(CHAIN_LEN), .NUM_VEC(NUM_VEC), .NUM_CHAINS(NUM_CHAINS),
      .CHAIN_IDX(c), .CNT_W(CNT_W), .VID_W(VID_W), .PAT_W(PAT_W),
      .STIM(STIM), .EXPECT(EXPECT), .CARE(CARE)
    ) u_lane (
      .load_en(load_en), .cmp_en(cmp_en), .load_vec(load_vec),
      .cur_vec(cur_vec), .bit_sel(bit_sel), .chain_out(scan_out[c]),
      .chain_in(scan_in[c]), .miss(miss[c])
    );
  end

  scan_seq_result #(.VID_W(VID_W)) u_result (
    .clk(clk), .rst_n(rst_int_n), .clear(accept), .miss_any(|miss),
    .cur_vec(cur_vec), .dev_fail(dev_fail), .fail_vec(fail_vec)
  );
endmodule

// File: rtl/scan_seq_chk.sv
module scan_seq_chk #(
  parameter int CHAIN_LEN = 8,
  parameter int VID_W     = 2
) (
  input logic             clk,
  input logic             rst_n,
  input logic             start,
  input logic             busy,
  input logic             done,
  input logic             scan_en,
  input logic             clk_en,
  input logic             dev_fail,
  input logic [VID_W-1:0] fail_vec
);
  localparam int SC_W = $clog2(CHAIN_LEN + 1) + 1;
  logic [SC_W-1:0] shift_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                  shift_cnt <= '0;
    else if (!busy)              shift_cnt <= '0;
    else if (clk_en && !scan_en) shift_cnt <= '0;
    else if (clk_en && scan_en)  shift_cnt <= shift_cnt + SC_W'(1);
  end

  p_launch_from_start_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(start));

  p_capture_single_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (clk_en && !scan_en) |=> (clk_en && scan_en));

  p_shift_span_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (clk_en && !scan_en) |-> (int'(shift_cnt) == CHAIN_LEN));

  p_fail_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (dev_fail && (busy || done || !start)) |=> (dev_fail && $stable(fail_vec)));

  p_done_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  p_done_after_run_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> done);

  p_clear_on_launch_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> (!dev_fail && fail_vec == '0));

  p_idle_no_shift_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !scan_en);
endmodule

bind scan_seq scan_seq_chk #(.CHAIN_LEN(CHAIN_LEN), .VID_W(VID_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .busy(busy), .done(done),
  .scan_en(scan_en), .clk_en(clk_en), .dev_fail(dev_fail), .fail_vec(fail_vec)
);

// File: tb/scan_seq_tb.sv
module scan_seq_tb;
  localparam int CLK_PERIOD = 10;
  localparam int L = 8;
  localparam int N = 4;
  localparam int C = 2;
  localparam int PW = N * C * L;
  localparam int RUN_CYC = (N + 1) * L + N;

  // byte k = v*C + c : v0c0=3C v0c1=18 v1c0=00 v1c1=FF v2c0=C3 v2c1=5A v3c0=81 v3c1=66
  localparam logic [PW-1:0] STIM = 64'h6681_5AC3_FF00_183C;
  // chain 1 flop 3 is never compared
  localparam logic [PW-1:0] CARE = 64'hF7FF_F7FF_F7FF_F7FF;

  // good device: flop j captures flop j AND flop j+1 (wrapping)
  function automatic logic [PW-1:0] good_resp(input logic [PW-1:0] s);
    logic [PW-1:0] r;
    r = '0;
    for (int k = 0; k < N * C; k++)
      for (int j = 0; j < L; j++)
        r[k*L+j] = s[k*L+j] & s[k*L+((j+1)%L)];
    return r;
  endfunction
  localparam logic [PW-1:0] EXPECT = good_resp(STIM);

  typedef struct packed {
    logic       flt;
    logic [0:0] ch;
    logic [2:0] node;
    logic       exp_fail;
    logic [1:0] exp_vec;
    logic       poke;
  } row_t;

  localparam int NROWS = 6;
  localparam row_t ROWS [NROWS] = '{
    '{1'b0, 1'b0, 3'd0, 1'b0, 2'd0, 1'b0},  // fault-free device
    '{1'b1, 1'b0, 3'd3, 1'b1, 2'd0, 1'b0},  // first seen in vector 0
    '{1'b1, 1'b0, 3'd0, 1'b1, 2'd2, 1'b0},  // first seen in vector 2
    '{1'b1, 1'b1, 3'd3, 1'b0, 2'd0, 1'b0},  // only on a don't-care column
    '{1'b1, 1'b1, 3'd4, 1'b1, 2'd1, 1'b0},  // second chain, vector 1
    '{1'b1, 1'b0, 3'd7, 1'b1, 2'd2, 1'b1}   // vectors 2 and 3 fail, start poked mid-run
  };

  logic clk, rst_n, start;
  logic [C-1:0] scan_out, scan_in;
  logic busy, done, scan_en, clk_en, dev_fail;
  logic [1:0] fail_vec;

  int checks = 0;
  int errors = 0;
  logic fault_on;
  int fault_c, fault_j;
  logic [L-1:0] chain_q [C];

  scan_seq #(
    .CHAIN_LEN(L), .NUM_VEC(N), .NUM_CHAINS(C),
    .STIM(STIM), .EXPECT(EXPECT), .CARE(CARE)
  ) u_dut (
    .clk(clk), .rst_n(rst_n), .start(start), .scan_out(scan_out),
    .busy(busy), .done(done), .scan_en(scan_en), .clk_en(clk_en),
    .scan_in(scan_in), .dev_fail(dev_fail), .fail_vec(fail_vec)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD / 2) clk = ~clk;

  // behavioural chains with an injectable stuck-at-0 capture node
  always @(posedge clk) begin
    if (clk_en) begin
      for (int c = 0; c < C; c++) begin
        if (scan_en) begin
          chain_q[c] <= {chain_q[c][L-2:0], scan_in[c]};
        end else begin
          for (int j = 0; j < L; j++) begin
            if (fault_on && fault_c == c && fault_j == j)
              chain_q[c][j] <= 1'b0;
            else
              chain_q[c][j] <= chain_q[c][j] & chain_q[c][(j+1)%L];
          end
        end
      end
    end
  end

  always_comb
    for (int c = 0; c < C; c++) scan_out[c] = chain_q[c][L-1];

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic run_row(input row_t r, input bit first);
    int busy_cyc, shift_cyc, capt_cyc, guard;
    logic [L-1:0] rec;
    fault_on = r.flt;
    fault_c  = int'(r.ch);
    fault_j  = int'(r.node);
    busy_cyc = 0; shift_cyc = 0; capt_cyc = 0; guard = 0; rec = '0;
    @(negedge clk) start = 1'b1;
    @(negedge clk) start = 1'b0;
    check("R2 busy after start", int'(busy), 1);
    while (!done && guard < 1000) begin
      if (busy) busy_cyc++;
      if (clk_en && scan_en) shift_cyc++;
      if (clk_en && !scan_en) capt_cyc++;
      if (busy_cyc <= L) rec = {rec[L-2:0], scan_in[0]};
      start = (r.poke && (busy_cyc == 10 || busy_cyc == 20)) ? 1'b1 : 1'b0;
      guard++;
      @(negedge clk);
    end
    start = 1'b0;
    if (guard >= 1000) check("R7 run never finished", 0, 1);
    if (first) check("R2 R9 first stimulus order", int'(rec), int'(STIM[L-1:0]));
    check("R3 capture cycles", capt_cyc, N);
    check(r.poke ? "R8 R4 busy length with start poke" : "R4 busy length", busy_cyc, RUN_CYC);
    check("R4 shift cycles", shift_cyc, RUN_CYC - N);
    check("R7 busy low at done", int'(busy), 0);
    check(r.flt && !r.exp_fail ? "R5 masked fault" : "R6 R9 fail flag", int'(dev_fail), int'(r.exp_fail));
    check("R6 first failing vector", int'(fail_vec), int'(r.exp_vec));
    @(negedge clk);
    check("R7 done one cycle", int'(done), 0);
    repeat (3) @(negedge clk);
    check("R7 result held", int'(dev_fail), int'(r.exp_fail));
    check("R7 index held", int'(fail_vec), int'(r.exp_vec));
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    errors++;
    $display("FAIL watchdog actual=hung expected=finished");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    rst_n = 1'b0; start = 1'b0; fault_on = 1'b0; fault_c = 0; fault_j = 0;
    repeat (3) @(negedge clk);
    check("R1 reset busy", int'(busy), 0);
    check("R1 reset clk_en", int'(clk_en), 0);
    check("R1 reset scan_en", int'(scan_en), 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check("R1 idle done", int'(done), 0);
    check("R1 idle dev_fail", int'(dev_fail), 0);
    check("R1 idle fail_vec", int'(fail_vec), 0);
    check("R1 idle busy", int'(busy), 0);
    for (int i = 0; i < NROWS; i++) run_row(ROWS[i], i == 0);
    // a passing run after a failing one clears the result
    run_row(ROWS[0], 1'b0);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule